// File: doc/BRIEF.md
# Timer DMA Burst Register Sequencer

This block lets a DMA engine reach a run of timer registers through one data-port address. Software sets a starting register offset and a run length in a small control register. A burst trigger, such as a timer update event, arms a burst and raises a DMA request. Each read or write the DMA engine then makes on the data port goes to the register at the starting offset plus a running index. The index advances after every access, and the request drops once the programmed number of transfers has been made.

The block drives the timer register file directly. It presents a register address and a write enable, merges byte-wide writes with the register's current contents, and returns read data to the data port. Offsets count from the first control register of the timer, so offset 0 is that register, 1 is the next one, 2 is the slave-mode control register, and so on. A target that falls past the last implemented register reads as zero and is never written. The index goes back to zero when a burst ends, so the next trigger starts a new burst at the beginning of the run.

Top module: `tmr_dma_burst_seq`

## Requirements
- R1: After reset, `ctl_rdata` is 0x0000, `dma_req` is low, and the burst index is 0.
- R2: A write to the control register stores the start offset from bits 4:0 and the length code from bits 12:8. All other bits, including 7:5 and 15:13, read back as zero, so writing 0xFFFF reads back as 0x1F1F.
- R3: A trigger that arrives while `dma_req` is low raises `dma_req` one cycle later, with the index at 0.
- R4: A data-port access presents `rf_addr` = start offset + index. A write (`dp_wr`) asserts `rf_we` in the same cycle, and a read (`dp_rd`) returns the register's contents on `dp_rdata`. The index advances by one after each access made while `dma_req` is high.
- R5: A length code L gives L+1 transfers, and any code above 17 gives 18 transfers. The start offset and transfer count are captured when the trigger arrives. On the cycle after the final access, `dma_req` is low and the index is 0, so the next trigger starts again at the start offset.
- R6: When start offset + index is 20 (NUM_REGS) or more, a read returns 0 and a write leaves `rf_we` low. The access still counts toward the burst.
- R7: A trigger that arrives while `dma_req` is high has no effect: the request stays high and the index does not change.
- R8: With `dp_byte` high, a read returns the low byte of the register zero-extended to 16 bits, and a write replaces only bits 7:0 while bits 15:8 keep their current value.
- R9: An access made while `dma_req` is low goes to the start offset itself and does not advance the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the burst control register |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read-back |
| trig | input | 1 | Burst trigger pulse |
| dp_rd | input | 1 | Read strobe on the DMA data-port address |
| dp_wr | input | 1 | Write strobe on the DMA data-port address |
| dp_byte | input | 1 | 1 selects an 8-bit transfer, 0 a 16-bit transfer |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data |
| rf_addr | output | 5 | Register-file address (low bits of offset + index) |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data at `rf_addr` |
| dma_req | output | 1 | DMA request, high while a burst is open |

## Verification
The bench counts transfers with length codes 0, 17 and 31. A design that decodes the length without the +1 ends one transfer early, and one without the clamp runs far past 18 transfers. It runs a burst whose targets wrap past offset 31 onto low register-file addresses. If the range check used only the truncated address, that burst would overwrite registers 0 and 1 and return their contents. It sends a second trigger in the middle of a burst and checks that the addresses continue, where a design that restarts would repeat the start offset. It also checks that byte writes keep the upper byte and that accesses outside a burst stay on the start offset without moving the index.

// File: rtl/tmr_dma_pkg.sv
package tmr_dma_pkg;
  localparam int FW = 5;

  typedef logic [FW-1:0] field_t;
  typedef logic [FW:0]   tgt_t;

  typedef struct packed {
    field_t len;
    field_t base;
  } burst_cfg_t;

  // Transfer count from a length code: code+1, never above max_total.
  function automatic field_t burst_total(input field_t len_code, input field_t max_total);
    if (len_code >= max_total) return max_total;
    return len_code + 1'b1;
  endfunction

  // Full-width target offset, kept one bit wider so overruns are visible.
  function automatic tgt_t target_of(input field_t base, input field_t idx);
    return {1'b0, base} + {1'b0, idx};
  endfunction

  function automatic logic target_valid(input tgt_t tgt, input int num_regs);
    return int'(tgt) < num_regs;
  endfunction
endpackage

// File: rtl/tmr_dma_ctl_reg.sv
module tmr_dma_ctl_reg
  import tmr_dma_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LEN_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output burst_cfg_t        cfg,
  output logic [DATA_W-1:0] rdata
);
  burst_cfg_t cfg_q;
  logic       unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.base <= wdata[FW-1:0];
      cfg_q.len  <= wdata[LEN_LSB +: FW];
    end
  end

  always_comb begin
    rdata                 = '0;
    rdata[FW-1:0]         = cfg_q.base;
    rdata[LEN_LSB +: FW]  = cfg_q.len;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tmr_dma_burst_ctr.sv
module tmr_dma_burst_ctr
  import tmr_dma_pkg::*;
#(
  parameter int MAX_XFERS = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  burst_cfg_t cfg,
  input  logic       trig,
  input  logic       acc,
  output logic       active,
  output field_t     idx,
  output field_t     total,
  output field_t     cur_base,
  output logic       last
);
  localparam field_t MAX_T = field_t'(MAX_XFERS);

  logic   active_q;
  field_t idx_q;
  field_t total_q;
  field_t base_q;
  logic   start;
  logic   step;

  assign start = trig && !active_q;
  assign step  = acc && active_q;
  assign last  = active_q && (field_t'(idx_q + 1'b1) == total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      total_q  <= '0;
      base_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      total_q  <= burst_total(cfg.len, MAX_T);
      base_q   <= cfg.base;
    end else if (step) begin
      if (last) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q    <= idx_q + 1'b1;
      end
    end
  end

  assign active   = active_q;
  assign idx      = idx_q;
  assign total    = total_q;
  assign cur_base = active_q ? base_q : cfg.base;
endmodule

// File: rtl/tmr_dma_addr_map.sv
module tmr_dma_addr_map
  import tmr_dma_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 20
) (
  input  field_t            base,
  input  field_t            idx,
  input  logic              dp_rd,
  input  logic              dp_wr,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] dp_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [FW-1:0]     rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] dp_rdata,
  output tgt_t              tgt,
  output logic              tgt_ok
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] rd_shaped;
  logic              unused_rd;

  assign unused_rd = dp_rd;
  assign tgt     = target_of(base, idx);
  assign tgt_ok  = target_valid(tgt, NUM_REGS);
  assign rf_addr = tgt[FW-1:0];
  assign rf_we   = dp_wr && tgt_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign rf_wdata[7:0]  = dp_wdata[7:0];
      assign rd_shaped[7:0] = rf_rdata[7:0];
    end else begin : g_high
      assign rf_wdata[g*8 +: 8]  = byte_mode ? rf_rdata[g*8 +: 8] : dp_wdata[g*8 +: 8];
      assign rd_shaped[g*8 +: 8] = byte_mode ? 8'h00 : rf_rdata[g*8 +: 8];
    end
  end

  assign dp_rdata = tgt_ok ? rd_shaped : '0;
endmodule

// File: rtl/tmr_dma_burst_seq.sv
module tmr_dma_burst_seq
  import tmr_dma_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 20,
  parameter int MAX_XFERS = 18,
  parameter int LEN_LSB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              trig,
  input  logic              dp_rd,
  input  logic              dp_wr,
  input  logic              dp_byte,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [DATA_W-1:0] dp_rdata,
  output logic [FW-1:0]     rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              dma_req
);
  burst_cfg_t cfg;
  logic       acc;
  logic       burst_on;
  field_t     burst_idx;
  field_t     burst_total_q;
  field_t     burst_base;
  logic       burst_last;
  tgt_t       tgt_addr;
  logic       tgt_ok;

  assign acc = dp_rd || dp_wr;

  tmr_dma_ctl_reg #(.DATA_W(DATA_W), .LEN_LSB(LEN_LSB)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .cfg(cfg), .rdata(ctl_rdata)
  );

  tmr_dma_burst_ctr #(.MAX_XFERS(MAX_XFERS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .trig(trig), .acc(acc),
    .active(burst_on), .idx(burst_idx), .total(burst_total_q),
    .cur_base(burst_base), .last(burst_last)
  );

  tmr_dma_addr_map #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_map (
    .base(burst_base), .idx(burst_idx), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .byte_mode(dp_byte), .dp_wdata(dp_wdata), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .dp_rdata(dp_rdata), .tgt(tgt_addr), .tgt_ok(tgt_ok)
  );

  assign dma_req = burst_on;
endmodule

// File: rtl/tmr_dma_burst_seq_chk.sv
module tmr_dma_burst_seq_chk
  import tmr_dma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              acc,
  input logic              dp_rd,
  input logic              dma_req,
  input field_t            burst_idx,
  input field_t            burst_total_q,
  input logic              burst_last,
  input logic              tgt_ok,
  input logic              rf_we,
  input logic [DATA_W-1:0] dp_rdata,
  input logic [DATA_W-1:0] ctl_rdata
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:5] == 3'b000 && ctl_rdata[15:13] == 3'b000);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !dma_req) |=> (dma_req && burst_idx == '0));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && acc && !burst_last) |=> (burst_idx == field_t'($past(burst_idx) + 1'b1)));

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (burst_idx < burst_total_q));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && acc && burst_last) |=> (!dma_req && burst_idx == '0));

  p_no_oob_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> tgt_ok);

  p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && !tgt_ok) |-> (dp_rdata == '0));

  p_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && trig && !acc) |=> (dma_req && $stable(burst_idx)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !trig) |=> (burst_idx == '0));
endmodule

bind tmr_dma_burst_seq tmr_dma_burst_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .acc(acc), .dp_rd(dp_rd),
  .dma_req(dma_req), .burst_idx(burst_idx), .burst_total_q(burst_total_q),
  .burst_last(burst_last), .tgt_ok(tgt_ok), .rf_we(rf_we),
  .dp_rdata(dp_rdata), .ctl_rdata(ctl_rdata)
);

// File: tb/tmr_dma_burst_seq_bench.sv
module tmr_dma_burst_seq_bench;
  localparam int NREG = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        trig = 1'b0;
  logic        dp_rd = 1'b0;
  logic        dp_wr = 1'b0;
  logic        dp_byte = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic [4:0]  rf_addr;
  logic        rf_we;
  logic [15:0] rf_wdata;
  logic [15:0] rf_rdata;
  logic        dma_req;

  logic [15:0] mem  [0:NREG-1];
  logic [15:0] expm [0:NREG-1];
  logic        preload = 1'b0;

  int checks = 0;
  int bad = 0;
  logic [4:0]  s_addr;
  logic [15:0] s_rdata;
  logic        s_we;

  always #5 clk = ~clk;

  tmr_dma_burst_seq u_tmr_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .trig(trig), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .dp_byte(dp_byte), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .dma_req(dma_req)
  );

  assign rf_rdata = (int'(rf_addr) < NREG) ? mem[rf_addr] : 16'hDEAD;

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 16'h1000 + 16'(i) * 16'h0101;
    end else if (rf_we && int'(rf_addr) < NREG) begin
      mem[rf_addr] <= rf_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_preload();
    @(negedge clk); preload = 1'b1;
    @(negedge clk); preload = 1'b0;
    for (int i = 0; i < NREG; i++) expm[i] = 16'h1000 + 16'(i) * 16'h0101;
  endtask

  task automatic ctl_write(input logic [15:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic set_burst(input int base, input int len);
    ctl_write({3'b000, 5'(len), 3'b000, 5'(base)});
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic acc(input bit wr, input bit byt, input logic [15:0] wd);
    @(negedge clk); dp_rd = !wr; dp_wr = wr; dp_byte = byt; dp_wdata = wd;
    #1; s_addr = rf_addr; s_rdata = dp_rdata; s_we = rf_we;
    @(negedge clk); dp_rd = 1'b0; dp_wr = 1'b0; dp_byte = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctl_rdata after reset", 32'(ctl_rdata), 32'h0);
    chk("R1 dma_req after reset", 32'(dma_req), 32'h0);
    acc(1'b0, 1'b0, '0);
    chk("R1 index zero after reset", 32'(s_addr), 32'h0);
  endtask

  task automatic t_ctl();
    ctl_write(16'hFFFF);
    chk("R2 reserved bits read zero", 32'(ctl_rdata), 32'h1F1F);
    set_burst(6, 9);
    chk("R2 field placement", 32'(ctl_rdata), 32'h0906);
  endtask

  task automatic t_basic();
    set_burst(3, 3);
    pulse_trig();
    chk("R3 request raised", 32'(dma_req), 32'h1);
    for (int k = 0; k < 4; k++) begin
      acc(1'b0, 1'b0, '0);
      chk("R4 address base+index", 32'(s_addr), 32'(3 + k));
      chk("R4 read data", 32'(s_rdata), 32'(expm[3 + k]));
      chk("R5 request while burst open", 32'(dma_req), (k < 3) ? 32'h1 : 32'h0);
    end
    acc(1'b0, 1'b0, '0);
    chk("R9 idle access at base", 32'(s_addr), 32'h3);
    acc(1'b0, 1'b0, '0);
    chk("R9 idle access does not advance", 32'(s_addr), 32'h3);
    pulse_trig();
    acc(1'b0, 1'b0, '0);
    chk("R5 restart from index 0", 32'(s_addr), 32'h3);
    for (int k = 1; k < 4; k++) acc(1'b0, 1'b0, '0);
    chk("R5 second burst closed", 32'(dma_req), 32'h0);
  endtask

  task automatic t_write();
    set_burst(0, 1);
    pulse_trig();
    acc(1'b1, 1'b0, 16'hA5A5); expm[0] = 16'hA5A5;
    chk("R4 write enable", 32'(s_we), 32'h1);
    acc(1'b1, 1'b0, 16'h5A5A); expm[1] = 16'h5A5A;
    chk("R4 write to reg 0", 32'(mem[0]), 32'(expm[0]));
    chk("R4 write to reg 1", 32'(mem[1]), 32'(expm[1]));
    chk("R5 request after 2 writes", 32'(dma_req), 32'h0);
  endtask

  task automatic t_clamp(input int len, input int expect_n);
    int n;
    set_burst(0, len);
    pulse_trig();
    n = 0;
    while (dma_req && n < 40) begin
      acc(1'b0, 1'b0, '0);
      n++;
    end
    chk($sformatf("R5 transfer count for code %0d", len), 32'(n), 32'(expect_n));
  endtask

  task automatic t_oob();
    set_burst(17, 4);
    pulse_trig();
    for (int k = 0; k < 5; k++) begin
      acc(1'b0, 1'b0, '0);
      chk("R6 read past last register", 32'(s_rdata),
          (17 + k < NREG) ? 32'(expm[17 + k]) : 32'h0);
    end
    set_burst(30, 3);
    pulse_trig();
    for (int k = 0; k < 4; k++) begin
      acc(1'b1, 1'b0, 16'h7777);
      chk("R6 no write past last register", 32'(s_we), 32'h0);
    end
    chk("R6 reg 0 untouched", 32'(mem[0]), 32'(expm[0]));
    chk("R6 reg 1 untouched", 32'(mem[1]), 32'(expm[1]));
    chk("R6 burst still counted", 32'(dma_req), 32'h0);
  endtask

  task automatic t_retrig();
    set_burst(5, 2);
    pulse_trig();
    acc(1'b0, 1'b0, '0);
    pulse_trig();
    chk("R7 request held", 32'(dma_req), 32'h1);
    acc(1'b0, 1'b0, '0);
    chk("R7 index kept", 32'(s_addr), 32'h6);
    acc(1'b0, 1'b0, '0);
    chk("R7 burst ends on time", 32'(dma_req), 32'h0);
  endtask

  task automatic t_byte();
    set_burst(8, 1);
    pulse_trig();
    acc(1'b0, 1'b1, '0);
    chk("R8 byte read", 32'(s_rdata), 32'({8'h00, expm[8][7:0]}));
    acc(1'b1, 1'b1, 16'hCC33);
    expm[9] = {expm[9][15:8], 8'h33};
    chk("R8 byte write keeps upper", 32'(mem[9]), 32'(expm[9]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_preload();
    t_reset();
    t_ctl();
    t_basic();
    t_write();
    t_clamp(0, 1);
    t_clamp(17, 18);
    t_clamp(31, 18);
    t_oob();
    t_retrig();
    t_byte();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule